// File: doc/BRIEF.md
# Serial Configuration Master Controller

This block sequences how a serial bitstream is loaded into an SRAM-based programmable target. After reset it waits out a power-on delay. For that whole delay it pulls a shared open-drain status line low, which keeps the target from starting configuration. When the delay ends it releases the line and samples a chip-select input once. A high level means some other agent owns configuration, so the block becomes a passive slave and stops driving its clock and data pins. A low level means the block becomes the master. It pulls bytes from a ready/valid source and shifts them out least-significant bit first, on a clock derived from the system clock.

In master mode the chip-select input keeps working after the start. While data is still streaming, a high level on it means the target aborted. After the last bit, a high level within a window of extra clock pulses means the target reports it is done. An abort pulls the status line low. So does a missing done indication. With the restart option set, the line is held low for a fixed time, the source is told to rewind, and the stream starts again from its first bit. With the option clear, the block stays in the error condition until reset.

Top module: `cfg_master`

## Requirements
- R1: While `rst_n` is low, and then until the POR_CYCLES-th rising clock edge after `rst_n` goes high, `oe_pull_low` is 1. From that edge on it is 0, unless a later error occurs.
- R2: If `ncs_in` is 1 when the power-on delay ends, the block enters slave mode. `dclk_drive` and `data_drive` become 0 and stay 0, `src_ready` never asserts, and `dclk_out` never rises.
- R3: If `ncs_in` is 0 when the power-on delay ends, the block streams data. While streaming, `dclk_drive` and `data_drive` are 1. With a source that is always valid, successive rising edges of `dclk_out` are exactly 2*HALF_DIV clock cycles apart.
- R4: Bit k of the stream is bit (k mod 8) of byte floor(k/8), so each byte goes out least-significant bit first. `data_out` changes only while `dclk_out` is low and holds its value across each rising edge.
- R5: While no source byte is loaded, `dclk_out` stays low and produces no rising edge.
- R6: Exactly BIT_COUNT rising edges carry data. `data_complete` is 0 up to the edge before the last data edge and is 1 after the last one. From then on `src_ready` stays 0.
- R7: If `ncs_in` is 1 at a clock edge while data is still streaming, `oe_pull_low` is 1 from that edge on.
- R8: If `ncs_in` goes high after the last data bit and before the window closes, the block parks in a done state. In that state `oe_pull_low` is 0, `dclk_out` stays low and `src_ready` stays 0.
- R9: If `ncs_in` stays low after the last data bit, `oe_pull_low` becomes 1 at the DONE_WINDOW-th rising edge of `dclk_out` that follows the last data edge.
- R10: With `auto_restart_en` at 0, an error keeps `oe_pull_low` at 1 and `dclk_out` low until reset. `src_rewind` never asserts.
- R11: With `auto_restart_en` at 1, an error holds `oe_pull_low` at 1 for exactly RESTART_HOLD cycles. `src_rewind` pulses for one cycle at the end of that hold. The stream then restarts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_restart_en | input | 1 | 1 = restart configuration after an error |
| ncs_in | input | 1 | Chip-select / done sense from the target |
| src_data | input | BYTE_W | Byte from the bitstream source |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Block accepts the source byte |
| src_rewind | output | 1 | One-cycle pulse: source returns to its first byte |
| dclk_out | output | 1 | Configuration clock value |
| dclk_drive | output | 1 | 1 = drive dclk pin, 0 = pin is an input |
| data_out | output | 1 | Serial configuration data |
| data_drive | output | 1 | 1 = drive data pin, 0 = tri-state |
| oe_pull_low | output | 1 | 1 = pull open-drain status line low, 0 = release |
| data_complete | output | 1 | All BIT_COUNT bits have been clocked out |

## Verification
The assertions assume the source keeps a byte stable while it is valid and moves to its next byte only after a handshake or a rewind. They also assume `ncs_in` changes only between clock edges and is never raised in the same cycle as the last data edge. The stimulus meets both assumptions. It changes `ncs_in`, the option and the valid gating only on falling clock edges. Its source model moves its pointer only on an accepted byte or on `src_rewind`. Abort and done are raised a fixed number of rising `dclk_out` edges away from the end of the stream.

// File: rtl/cfg_master_pkg.sv
// Package: shared state encoding for the serial configuration master.
package cfg_master_pkg;

    // Controller states, from power-on delay to done or error.
    typedef enum logic [2:0] {
        ST_POR        = 3'd0,
        ST_MODE_CHECK = 3'd1,
        ST_SLAVE      = 3'd2,
        ST_SEND       = 3'd3,
        ST_DONE_WAIT  = 3'd4,
        ST_DONE       = 3'd5,
        ST_ERROR      = 3'd6
    } cfg_state_e;

endpackage

// File: rtl/cfg_step_timer.sv
// cfg_step_timer: counts qualified steps and flags the step that completes LIMIT.
// Assumes LIMIT >= 1. On the last step the count wraps to zero. 'clear' wins over 'tick'.
module cfg_step_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

    logic [W-1:0] cnt;

    // Flag the step that completes the limit.
    always_comb last = tick && (cnt == W'(LIMIT - 1));

    // Step counter with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_dclk_gen.sv
// cfg_dclk_gen: derives the configuration clock by dividing the system clock.
// Each half period lasts HALF system cycles. When 'stall' is set, the clock is
// held in its low phase and no rising edge occurs. 'rise' and 'fall' flag the
// cycle whose closing edge changes the clock.
// Assumes HALF >= 1. Dropping 'run' forces the clock low.
module cfg_dclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stall,
    output logic dclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          at_end;

    // Decode the end of a half period and the edge events.
    always_comb begin
        at_end = (cnt == CW'(HALF - 1));
        rise   = run && !dclk && at_end && !stall;
        fall   = run && dclk && at_end;
    end

    // Phase counter and clock register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            dclk <= 1'b0;
        end else if (rise || fall) begin
            cnt  <= '0;
            dclk <= ~dclk;
        end else if (!at_end) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_bit_shifter.sv
// cfg_bit_shifter: takes bytes from a ready/valid source and presents them
// least-significant bit first. It shifts on the falling edge of the
// configuration clock and counts bits on the rising edge.
// Assumes rise and fall never coincide, and that a byte is loaded only while
// the clock is low.
module cfg_bit_shifter #(
    parameter int BIT_COUNT = 1024,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              rise,
    input  logic              fall,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              complete
);
    localparam int SW   = $clog2(BYTE_W + 1);
    localparam int CNTW = $clog2(BIT_COUNT + 1);

    logic [BYTE_W-1:0] sh_reg;
    logic [SW-1:0]     sh_left;
    logic [CNTW-1:0]   sent;

    // Handshake and status decode.
    always_comb begin
        complete  = (sent == CNTW'(BIT_COUNT));
        bit_valid = (sh_left != '0);
        src_ready = enable && !bit_valid && !complete;
        bit_out   = sh_reg[0];
    end

    // Shift register holding the byte being sent.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_reg  <= '0;
            sh_left <= '0;
        end else if (src_valid && src_ready) begin
            sh_reg  <= src_data;
            sh_left <= SW'(BYTE_W);
        end else if (fall && bit_valid) begin
            sh_reg  <= {1'b0, sh_reg[BYTE_W-1:1]};
            sh_left <= sh_left - 1'b1;
        end
    end

    // Count of bits clocked into the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sent <= '0;
        end else if (rise && !complete) begin
            sent <= sent + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_master.sv
// cfg_master: serial configuration master controller.
// It holds off configuration for a power-on delay, then picks master or slave
// mode from ncs_in. In master mode it streams BIT_COUNT bits, watches ncs_in
// for an abort and then for done, and signals errors by pulling the
// open-drain status line low. It can restart configuration after an error.
// Assumes the source rewinds to its first byte on src_rewind. The reset is
// synchronous and active-low.
module cfg_master
    import cfg_master_pkg::*;
#(
    parameter int POR_CYCLES   = 50000,
    parameter int HALF_DIV     = 2,
    parameter int BIT_COUNT    = 1024,
    parameter int BYTE_W       = 8,
    parameter int DONE_WINDOW  = 16,
    parameter int RESTART_HOLD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_restart_en,
    input  logic              ncs_in,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic              src_rewind,
    output logic              dclk_out,
    output logic              dclk_drive,
    output logic              data_out,
    output logic              data_drive,
    output logic              oe_pull_low,
    output logic              data_complete
);
    cfg_state_e state, state_nx;

    logic por_last, win_last, hold_last;
    logic dclk_rise, dclk_fall, bit_valid;
    logic in_por, in_send, in_wait, in_err;

    // State decodes that feed the sub-blocks.
    always_comb begin
        in_por  = (state == ST_POR);
        in_send = (state == ST_SEND);
        in_wait = (state == ST_DONE_WAIT);
        in_err  = (state == ST_ERROR);
    end

    // Power-on delay timer.
    cfg_step_timer #(.LIMIT(POR_CYCLES)) por_tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(!in_por), .tick(in_por), .last(por_last)
    );

    // Done-window timer, stepped by configuration clock rising edges.
    cfg_step_timer #(.LIMIT(DONE_WINDOW)) win_tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(!in_wait), .tick(in_wait && dclk_rise),
        .last(win_last)
    );

    // Restart hold timer, runs only while restart is enabled.
    cfg_step_timer #(.LIMIT(RESTART_HOLD)) hold_tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(!in_err), .tick(in_err && auto_restart_en),
        .last(hold_last)
    );

    // Configuration clock divider.
    cfg_dclk_gen #(.HALF(HALF_DIV)) dclk_i (
        .clk(clk), .rst_n(rst_n), .run(in_send || in_wait),
        .stall(in_send && !bit_valid), .dclk(dclk_out), .rise(dclk_rise), .fall(dclk_fall)
    );

    // Byte-to-bit serialiser and bit counter.
    cfg_bit_shifter #(.BIT_COUNT(BIT_COUNT), .BYTE_W(BYTE_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .clear(in_err || in_por), .enable(in_send),
        .rise(dclk_rise), .fall(dclk_fall), .src_data(src_data), .src_valid(src_valid),
        .src_ready(src_ready), .bit_out(data_out), .bit_valid(bit_valid),
        .complete(data_complete)
    );

    // Next-state logic of the configuration sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POR:        if (por_last) state_nx = ST_MODE_CHECK;
            ST_MODE_CHECK: state_nx = ncs_in ? ST_SLAVE : ST_SEND;
            ST_SLAVE:      state_nx = ST_SLAVE;
            ST_SEND: begin
                if (data_complete)   state_nx = ST_DONE_WAIT;
                else if (ncs_in)     state_nx = ST_ERROR;
            end
            ST_DONE_WAIT: begin
                if (ncs_in)          state_nx = ST_DONE;
                else if (win_last)   state_nx = ST_ERROR;
            end
            ST_DONE:       state_nx = ST_DONE;
            ST_ERROR:      if (hold_last) state_nx = ST_SEND;
            default:       state_nx = ST_POR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_POR;
        else        state <= state_nx;
    end

    // Pin controls derived from the state.
    always_comb begin
        oe_pull_low = in_por || in_err;
        dclk_drive  = (state != ST_SLAVE);
        data_drive  = (state != ST_SLAVE);
        src_rewind  = in_err && hold_last;
    end
endmodule

// File: rtl/cfg_master_chk.sv
// cfg_master_chk: temporal checks on cfg_master, attached through bind.
// Assumes ncs_in changes only between clock edges.
module cfg_master_chk
    import cfg_master_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cfg_state_e state,
    input logic       auto_restart_en,
    input logic       ncs_in,
    input logic       src_ready,
    input logic       src_rewind,
    input logic       dclk_out,
    input logic       dclk_drive,
    input logic       data_out,
    input logic       data_drive,
    input logic       oe_pull_low,
    input logic       data_complete
);
    p_data_hold_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_out) |-> $stable(data_out));

    p_abort_pulls_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && ncs_in && !data_complete) |=> oe_pull_low);

    p_slave_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dclk_drive |=> (!dclk_drive && !data_drive && !src_ready));

    p_no_fetch_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_complete |-> !src_ready);

    p_rewind_then_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_rewind |-> (oe_pull_low && auto_restart_en) ##1 !oe_pull_low);

    p_done_clock_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !dclk_out);
endmodule

bind cfg_master cfg_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .auto_restart_en(auto_restart_en),
    .ncs_in(ncs_in), .src_ready(src_ready), .src_rewind(src_rewind),
    .dclk_out(dclk_out), .dclk_drive(dclk_drive), .data_out(data_out),
    .data_drive(data_drive), .oe_pull_low(oe_pull_low), .data_complete(data_complete)
);

// File: tb/cfg_master_tb_top.sv
module cfg_master_tb_top;
    localparam int P_POR  = 20;
    localparam int P_HALF = 2;
    localparam int P_BITS = 24;
    localparam int P_WIN  = 4;
    localparam int P_HOLD = 6;
    localparam int NB     = P_BITS / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_restart_en = 1'b0;
    logic ncs_in = 1'b0;
    logic [7:0] src_data;
    logic src_valid, src_ready, src_rewind;
    logic dclk_out, dclk_drive, data_out, data_drive, oe_pull_low, data_complete;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done_flag = 1'b0;
    logic last_dclk = 1'b0;
    bit  rose = 1'b0;
    logic prev_data = 1'b0;
    logic cur_data  = 1'b0;
    logic [7:0] mem [NB];
    int  ptr = 0;
    bit  gap_force = 1'b0;
    bit  gap_mode  = 1'b0;

    always #2 clk = ~clk;

    assign src_valid = (ptr < NB) && !gap_force && !(gap_mode && (cyc % 3 != 0));
    assign src_data  = (ptr < NB) ? mem[ptr] : 8'h00;

    // Source model: advance on handshake, return to the start on rewind.
    always @(posedge clk) begin
        if (!rst_n)                       ptr <= 0;
        else if (src_rewind)              ptr <= 0;
        else if (src_valid && src_ready)  ptr <= ptr + 1;
    end

    cfg_master #(
        .POR_CYCLES(P_POR), .HALF_DIV(P_HALF), .BIT_COUNT(P_BITS), .BYTE_W(8),
        .DONE_WINDOW(P_WIN), .RESTART_HOLD(P_HOLD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .auto_restart_en(auto_restart_en), .ncs_in(ncs_in),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .src_rewind(src_rewind), .dclk_out(dclk_out), .dclk_drive(dclk_drive),
        .data_out(data_out), .data_drive(data_drive), .oe_pull_low(oe_pull_low),
        .data_complete(data_complete)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // One cycle, sampled on the falling edge.
    task automatic tick();
        @(negedge clk);
        cyc++;
        rose      = dclk_out && !last_dclk;
        last_dclk = dclk_out;
        prev_data = cur_data;
        cur_data  = data_out;
    endtask

    task automatic wait_rise(output int gap, output bit ok);
        gap = 0;
        ok  = 1'b0;
        while (gap < 300) begin
            tick();
            gap++;
            if (rose) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // Reset and power-on delay; R1.
    task automatic do_reset(input bit ncs_v, input bit auto_v);
        int lows;
        rst_n = 1'b0;
        ncs_in = ncs_v;
        auto_restart_en = auto_v;
        gap_force = 1'b0;
        gap_mode  = 1'b0;
        repeat (3) tick();
        check("R1", "oe low in reset", int'(oe_pull_low), 1);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 1000; i++) begin
            tick();
            if (!oe_pull_low) break;
            lows++;
        end
        // Low after edges 1..P_POR-1, released at edge P_POR (R1).
        check("R1", "oe low samples after reset release", lows, P_POR - 1);
    endtask

    task automatic fill(input int s);
        for (int i = 0; i < NB; i++)
            mem[i] = 8'((s * 53 + i * 29 + 7) * 13) ^ 8'(s << 4);
    endtask

    // Capture a full stream and check order, hold, spacing and completion.
    task automatic capture(input bit strict_period);
        int gap;
        bit ok;
        int bad_order = 0;
        int bad_hold = 0;
        int bad_per = 0;
        int bad_cmp = 0;
        for (int i = 0; i < P_BITS; i++) begin
            wait_rise(gap, ok);
            if (!ok) begin
                check("R6", "rising edge missing at bit", i, -1);
                return;
            end
            if (data_out !== mem[i / 8][i % 8]) bad_order++;
            if (cur_data !== prev_data) bad_hold++;
            if (i > 0 && strict_period && gap != 2 * P_HALF) bad_per++;
            if (i > 0 && !strict_period && gap < 2 * P_HALF) bad_per++;
            if (int'(data_complete) != int'(i == P_BITS - 1)) bad_cmp++;
            if (i == 1) begin
                check("R3", "dclk_drive in master", int'(dclk_drive), 1);
                check("R3", "data_drive in master", int'(data_drive), 1);
            end
        end
        check("R4", "bits out of LSB-first order", bad_order, 0);
        check("R4", "data changed across rise", bad_hold, 0);
        check("R3", "bad dclk spacing", bad_per, 0);
        check("R6", "data_complete timing errors", bad_cmp, 0);
        check("R6", "src_ready after complete", int'(src_ready), 0);
    endtask

    task automatic expect_done();
        int gap;
        bit ok;
        int rises = 0;
        int readies = 0;
        int oes = 0;
        wait_rise(gap, ok);
        ncs_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (i > 2) begin
                if (rose) rises++;
                if (src_ready) readies++;
                if (oe_pull_low) oes++;
            end
        end
        check("R8", "oe low samples in done", oes, 0);
        check("R8", "dclk rises in done", rises, 0);
        check("R8", "dclk level in done", int'(dclk_out), 0);
        check("R8", "src_ready in done", readies, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        // Session 0: plain stream, done seen inside the window.
        fill(0);
        do_reset(1'b0, 1'b0);
        capture(1'b1);
        expect_done();

        // Session 1: source stalled, then gapped; window expires, no restart.
        begin
            int rises = 0;
            int lows = 0;
            int rw = 0;
            fill(1);
            gap_force = 1'b1;
            do_reset(1'b0, 1'b0);
            gap_force = 1'b1;
            for (int i = 0; i < 30; i++) begin
                tick();
                if (rose) rises++;
            end
            check("R5", "rises with no byte loaded", rises, 0);
            check("R5", "dclk level while stalled", int'(dclk_out), 0);
            gap_force = 1'b0;
            gap_mode  = 1'b1;
            capture(1'b0);
            gap_mode = 1'b0;
            rises = 0;
            for (int i = 0; i < 200; i++) begin
                tick();
                if (rose) rises++;
                if (oe_pull_low) break;
            end
            check("R9", "window rises before error", rises, P_WIN);
            rises = 0;
            for (int i = 0; i < 40; i++) begin
                tick();
                if (oe_pull_low) lows++;
                if (rose) rises++;
                if (src_rewind) rw++;
            end
            check("R10", "oe low samples without restart", lows, 40);
            check("R10", "dclk rises in error", rises, 0);
            check("R10", "rewind pulses without restart", rw, 0);
        end

        // Session 2: abort mid-stream, automatic restart from bit 0.
        begin
            int gap;
            bit ok;
            int lows = 0;
            int rw = 0;
            fill(2);
            do_reset(1'b0, 1'b1);
            for (int i = 0; i < 10; i++) wait_rise(gap, ok);
            check("R7", "oe before abort", int'(oe_pull_low), 0);
            ncs_in = 1'b1;
            tick();
            check("R7", "oe one cycle after abort", int'(oe_pull_low), 1);
            ncs_in = 1'b0;
            lows = 1;
            for (int i = 0; i < 100; i++) begin
                if (src_rewind) rw++;
                tick();
                if (!oe_pull_low) break;
                lows++;
            end
            check("R11", "restart hold length", lows, P_HOLD);
            check("R11", "rewind pulses", rw, 1);
            last_dclk = dclk_out;
            capture(1'b1);
            expect_done();
        end

        // Session 3: chip select high at end of power-on delay selects slave.
        begin
            int rises = 0;
            int readies = 0;
            int drives = 0;
            fill(3);
            do_reset(1'b1, 1'b0);
            for (int i = 0; i < 40; i++) begin
                tick();
                if (i > 1) begin
                    if (rose) rises++;
                    if (src_ready) readies++;
                    if (dclk_drive || data_drive) drives++;
                end
            end
            check("R2", "slave pin drive samples", drives, 0);
            check("R2", "slave src_ready samples", readies, 0);
            check("R2", "slave dclk rises", rises, 0);
            check("R2", "slave oe released", int'(oe_pull_low), 0);
        end

        finish_run();
    end
endmodule